// File: doc/BRIEF.md
# Cross-Processor Operand Ring

This block moves single data operands around a one-way ring of virtual processor (VP) slots. Each slot has a send port that hands a value to its successor and a receive port that takes a value from its predecessor. No other path between slots exists. Every hop between neighbouring slots is a single-entry holding register with a valid/ready handshake.

The closing hop is different. A value sent by the highest-numbered active slot is not handed straight back to slot 0. It goes into a parameterised first-in first-out wrap queue, and slot 0 reads its predecessor operand from the head of that queue. A control-processor port shares the queue. It can push seed values in and pop results out. VP traffic wins over the control port on both sides of the queue.

The number of active slots is a runtime input, so the wrap point moves with it. Transfers are scheduled only by the handshakes. A receiver simply waits until its predecessor's value is present, so senders and receivers may run with any relative latency.

Top module: `xvp_ring`

## Requirements
- R1: After reset every hop register and the wrap queue are empty: `recvValid` is all zero, `cpPopValid` is 0, `cpPushReady` is 1 and every active slot has `sendReady` high.
- R2: A value accepted from slot k (k not the last active slot) appears on slot k+1's receive port, with `recvValid[k+1]` high, in the cycle after the send handshake. It appears on no other slot.
- R3: A hop register holds one value. While it is full, `sendReady` of its sender is low. It frees in the cycle after the receiver accepts.
- R4: A value sent by the last active slot enters the wrap queue. Slot 0 then sees it at the queue head (`recvValid[0]` high) in the next cycle, and slot 1 does not see it.
- R5: The effective active count is `activeCnt`, except that 0 counts as 1 and values above NUM_VP count as NUM_VP. Slots at or above the effective count have `sendReady` and `recvValid` low, even when a hop register feeding them still holds data.
- R6: A control push is accepted when `cpPushValid` and `cpPushReady` are both high. `cpPushReady` is low while the queue is full or while the last active slot is sending into a non-full queue in the same cycle, so VP writes take priority.
- R7: `cpPopValid` is high only when the queue is non-empty and `recvReady[0]` is low. Slot 0 has priority at the queue head, and `cpPopData` equals the head value.
- R8: The wrap queue (depth FIFO_DEPTH, default 4) returns values in arrival order. When it is full, `cpPushReady` and the last active slot's `sendReady` are low and a push is not stored. When it is empty, `cpPopValid` and `recvValid[0]` are low.
- R9: A receiver with `recvReady` low leaves the value in place. `recvValid` and the data stay unchanged until the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| activeCnt | input | $clog2(NUM_VP+1) | Number of active slots (wrap point) |
| sendValid | input | NUM_VP | Per-slot send request |
| sendData | input | NUM_VP*DATA_W | Per-slot send operand, slot k in bits k*DATA_W upward |
| sendReady | output | NUM_VP | Per-slot send accepted |
| recvValid | output | NUM_VP | Per-slot predecessor operand present |
| recvData | output | NUM_VP*DATA_W | Per-slot received operand, slot k in bits k*DATA_W upward |
| recvReady | input | NUM_VP | Per-slot receive consume |
| cpPushValid | input | 1 | Control push request |
| cpPushData | input | DATA_W | Control push operand |
| cpPushReady | output | 1 | Control push accepted |
| cpPopValid | output | 1 | Queue head offered to control port |
| cpPopData | output | DATA_W | Queue head value |
| cpPopReady | input | 1 | Control pop consume |

## Verification
Two situations are hard to reach. The first is a hop register that holds data while its receiving slot has just been made inactive. The stimulus fills the hop from slot 1 to slot 2 with four slots active, lowers the count to two while that data sits there, checks that slot 2 shows nothing, and then raises the count again to recover the value. The second is contention on the wrap queue. The bench drives a last-slot send and a control push in the same cycle, and a slot 0 read together with a pending control pop, then checks the order in which values come out.

// File: rtl/xvp_pkg.sv
package xvp_pkg;
  // strobes from the control module to the wrap-queue storage
  typedef struct packed {
    logic wrEn;      // write one entry this cycle
    logic wrFromVp;  // 1: source is last active slot, 0: control push
    logic rdEn;      // retire the head entry this cycle
  } fifoCtl_t;
endpackage

// File: rtl/xvp_ctrl.sv
module xvp_ctrl
  import xvp_pkg::*;
#(
  parameter int NUM_VP = 4,
  localparam int LINKS = NUM_VP - 1,
  localparam int CNT_W = $clog2(NUM_VP + 1),
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] activeCnt,
  input  logic [NUM_VP-1:0] sendValid,
  input  logic [NUM_VP-1:0] recvReady,
  input  logic             cpPushValid,
  input  logic             cpPopReady,
  input  logic [LINKS-1:0] linkFull,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  output logic [NUM_VP-1:0] sendReady,
  output logic [NUM_VP-1:0] recvValid,
  output logic             cpPushReady,
  output logic             cpPopValid,
  output logic [LINKS-1:0] linkLoad,
  output logic [LINKS-1:0] linkDrain,
  output logic [IDX_W-1:0] lastIdx,
  output fifoCtl_t         fifoCtl
);
  logic [CNT_W-1:0] effCnt;
  logic [NUM_VP-1:0] activeMask;
  logic [NUM_VP-1:0] linkFullExt;
  logic vpWr;
  logic vp0Take;

  always_comb begin
    if (activeCnt == '0)                     effCnt = CNT_W'(1);
    else if (activeCnt > CNT_W'(NUM_VP))     effCnt = CNT_W'(NUM_VP);
    else                                     effCnt = activeCnt;
    lastIdx = IDX_W'(effCnt - CNT_W'(1));
    for (int k = 0; k < NUM_VP; k++) activeMask[k] = (CNT_W'(k) < effCnt);
  end

  assign linkFullExt = {1'b1, linkFull};

  always_comb begin
    for (int k = 0; k < NUM_VP; k++) begin
      if (!activeMask[k])               sendReady[k] = 1'b0;
      else if (IDX_W'(k) == lastIdx)    sendReady[k] = !fifoFull;
      else                              sendReady[k] = !linkFullExt[k];
    end
    for (int k = 0; k < LINKS; k++)
      linkLoad[k] = sendValid[k] && sendReady[k] && (IDX_W'(k) != lastIdx);
    recvValid[0] = !fifoEmpty;
    for (int k = 1; k < NUM_VP; k++)
      recvValid[k] = activeMask[k] && linkFull[k-1];
    for (int k = 0; k < LINKS; k++)
      linkDrain[k] = recvValid[k+1] && recvReady[k+1];
  end

  assign vpWr        = sendValid[lastIdx] && !fifoFull;
  assign cpPushReady = !fifoFull && !vpWr;
  assign vp0Take     = !fifoEmpty && recvReady[0];
  assign cpPopValid  = !fifoEmpty && !recvReady[0];

  assign fifoCtl.wrEn     = vpWr || (cpPushValid && cpPushReady);
  assign fifoCtl.wrFromVp = vpWr;
  assign fifoCtl.rdEn     = vp0Take || (cpPopValid && cpPopReady);

  // R7: slot 0 wins the queue head over the control pop
  a_r7_vp0_first: assert property (@(posedge clk) disable iff (!rstN)
    recvReady[0] |-> !cpPopValid);

  // R6: a control push never coincides with a slot write
  a_r6_push_yields: assert property (@(posedge clk) disable iff (!rstN)
    (cpPushValid && cpPushReady) |-> !(sendValid[lastIdx] && sendReady[lastIdx]));

  // R5: inactive slots stay silent
  generate
    for (genvar g = 0; g < NUM_VP; g++) begin : g_quiet
      a_r5_inactive_quiet: assert property (@(posedge clk) disable iff (!rstN)
        (CNT_W'(g) >= effCnt) |-> (!sendReady[g] && !recvValid[g]));
    end
  endgenerate
endmodule

// File: rtl/xvp_dpath.sv
module xvp_dpath
  import xvp_pkg::*;
#(
  parameter int NUM_VP     = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int LINKS = NUM_VP - 1,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1,
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int QCNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_VP*DATA_W-1:0] sendData,
  input  logic [DATA_W-1:0]        cpPushData,
  input  logic [IDX_W-1:0]         lastIdx,
  input  logic [LINKS-1:0]         linkLoad,
  input  logic [LINKS-1:0]         linkDrain,
  input  fifoCtl_t                 fifoCtl,
  output logic [LINKS-1:0]         linkFull,
  output logic [LINKS*DATA_W-1:0]  linkData,
  output logic                     fifoFull,
  output logic                     fifoEmpty,
  output logic [DATA_W-1:0]        headData
);
  logic [DATA_W-1:0] vpData [NUM_VP];
  logic [DATA_W-1:0] qMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [QCNT_W-1:0] qCount;
  logic [DATA_W-1:0] wrData;

  generate
    for (genvar g = 0; g < NUM_VP; g++) begin : g_unpack
      assign vpData[g] = sendData[g*DATA_W +: DATA_W];
    end

    for (genvar g = 0; g < LINKS; g++) begin : g_link
      always_ff @(posedge clk) begin
        if (!rstN) begin
          linkFull[g] <= 1'b0;
        end else if (linkLoad[g]) begin
          linkFull[g] <= 1'b1;
          linkData[g*DATA_W +: DATA_W] <= vpData[g];
        end else if (linkDrain[g]) begin
          linkFull[g] <= 1'b0;
        end
      end

      // R3: a full hop is never overwritten
      a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
        linkLoad[g] |-> !linkFull[g]);
      // R9: an unconsumed hop keeps its value
      a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
        (linkFull[g] && !linkDrain[g]) |=>
          (linkFull[g] && $stable(linkData[g*DATA_W +: DATA_W])));
    end
  endgenerate

  assign wrData = fifoCtl.wrFromVp ? vpData[lastIdx] : cpPushData;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (fifoCtl.wrEn) qMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (fifoCtl.wrEn) wrPtr <= bump(wrPtr);
      if (fifoCtl.rdEn) rdPtr <= bump(rdPtr);
      case ({fifoCtl.wrEn, fifoCtl.rdEn})
        2'b10:   qCount <= qCount + QCNT_W'(1);
        2'b01:   qCount <= qCount - QCNT_W'(1);
        default: qCount <= qCount;
      endcase
    end
  end

  assign fifoFull  = (qCount == QCNT_W'(FIFO_DEPTH));
  assign fifoEmpty = (qCount == '0);
  assign headData  = qMem[rdPtr];

  // R8: queue never overflows or underflows
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoCtl.wrEn |-> !fifoFull);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoCtl.rdEn |-> !fifoEmpty);
endmodule

// File: rtl/xvp_ring.sv
module xvp_ring
  import xvp_pkg::*;
#(
  parameter int NUM_VP     = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(NUM_VP + 1),
  localparam int LINKS = NUM_VP - 1,
  localparam int IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CNT_W-1:0]         activeCnt,
  input  logic [NUM_VP-1:0]        sendValid,
  input  logic [NUM_VP*DATA_W-1:0] sendData,
  output logic [NUM_VP-1:0]        sendReady,
  output logic [NUM_VP-1:0]        recvValid,
  output logic [NUM_VP*DATA_W-1:0] recvData,
  input  logic [NUM_VP-1:0]        recvReady,
  input  logic                     cpPushValid,
  input  logic [DATA_W-1:0]        cpPushData,
  output logic                     cpPushReady,
  output logic                     cpPopValid,
  output logic [DATA_W-1:0]        cpPopData,
  input  logic                     cpPopReady
);
  logic [LINKS-1:0]        linkFull, linkLoad, linkDrain;
  logic [LINKS*DATA_W-1:0] linkData;
  logic                    fifoFull, fifoEmpty;
  logic [DATA_W-1:0]       headData;
  logic [IDX_W-1:0]        lastIdx;
  fifoCtl_t                fifoCtl;

  xvp_ctrl #(.NUM_VP(NUM_VP)) i_ctrl (
    .clk(clk), .rstN(rstN), .activeCnt(activeCnt),
    .sendValid(sendValid), .recvReady(recvReady),
    .cpPushValid(cpPushValid), .cpPopReady(cpPopReady),
    .linkFull(linkFull), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .sendReady(sendReady), .recvValid(recvValid),
    .cpPushReady(cpPushReady), .cpPopValid(cpPopValid),
    .linkLoad(linkLoad), .linkDrain(linkDrain),
    .lastIdx(lastIdx), .fifoCtl(fifoCtl)
  );

  xvp_dpath #(.NUM_VP(NUM_VP), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) i_dpath (
    .clk(clk), .rstN(rstN), .sendData(sendData), .cpPushData(cpPushData),
    .lastIdx(lastIdx), .linkLoad(linkLoad), .linkDrain(linkDrain),
    .fifoCtl(fifoCtl), .linkFull(linkFull), .linkData(linkData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headData(headData)
  );

  assign recvData  = {linkData, headData};
  assign cpPopData = headData;
endmodule

// File: tb/test_xvp_ring.sv
module test_xvp_ring;
  localparam int NV = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    activeCnt = 3'd4;
  logic [NV-1:0] sendValid = '0;
  logic [NV*DW-1:0] sendData = '0;
  logic [NV-1:0] sendReady, recvValid;
  logic [NV*DW-1:0] recvData;
  logic [NV-1:0] recvReady = '0;
  logic          cpPushValid = 1'b0;
  logic [DW-1:0] cpPushData = '0;
  logic          cpPushReady, cpPopValid;
  logic [DW-1:0] cpPopData;
  logic          cpPopReady = 1'b0;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  xvp_ring i_xvp_ring (
    .clk(clk), .rstN(rstN), .activeCnt(activeCnt),
    .sendValid(sendValid), .sendData(sendData), .sendReady(sendReady),
    .recvValid(recvValid), .recvData(recvData), .recvReady(recvReady),
    .cpPushValid(cpPushValid), .cpPushData(cpPushData), .cpPushReady(cpPushReady),
    .cpPopValid(cpPopValid), .cpPopData(cpPopData), .cpPopReady(cpPopReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd(input int k);
    return recvData[k*DW +: DW];
  endfunction

  task automatic t_reset();
    #1;
    chk("R1", 32'(recvValid), 32'h0, "recvValid");
    chk("R1", 32'(cpPopValid), 32'h0, "cpPopValid");
    chk("R1", 32'(cpPushReady), 32'h1, "cpPushReady");
    chk("R1", 32'(sendReady), 32'hF, "sendReady");
  endtask

  task automatic t_chain();
    sendValid = 4'b0001; sendData[0 +: DW] = 16'h1111;
    #1 chk("R2", 32'(sendReady[0]), 32'h1, "slot0 ready");
    @(negedge clk); sendValid = '0;
    #1 chk("R2", 32'(recvValid), 32'h2, "only slot1 valid");
    chk("R2", 32'(rd(1)), 32'h1111, "slot1 data");
    chk("R3", 32'(sendReady[0]), 32'h0, "slot0 stalled on full hop");
    @(negedge clk);
    #1 chk("R9", 32'(recvValid), 32'h2, "held while not ready");
    chk("R9", 32'(rd(1)), 32'h1111, "held data");
    recvReady = 4'b0010;
    @(negedge clk); recvReady = '0;
    #1 chk("R9", 32'(recvValid), 32'h0, "consumed");
    chk("R3", 32'(sendReady[0]), 32'h1, "hop freed");
    sendValid = 4'b0010; sendData[1*DW +: DW] = 16'h2222;
    @(negedge clk); sendValid = '0;
    #1 chk("R2", 32'(recvValid), 32'h4, "slot2 valid");
    chk("R2", 32'(rd(2)), 32'h2222, "slot2 data");
    recvReady = 4'b0100;
    @(negedge clk); recvReady = '0;
  endtask

  task automatic t_wrap();
    sendValid = 4'b1000; sendData[3*DW +: DW] = 16'hA5A5;
    #1 chk("R4", 32'(sendReady[3]), 32'h1, "last slot ready");
    @(negedge clk); sendValid = '0;
    #1 chk("R4", 32'(recvValid), 32'h1, "wrap reaches slot0 only");
    chk("R4", 32'(rd(0)), 32'hA5A5, "slot0 data");
    chk("R7", 32'(cpPopValid), 32'h1, "pop offered when slot0 idle");
    chk("R7", 32'(cpPopData), 32'hA5A5, "pop data is head");
    recvReady = 4'b0001;
    #1 chk("R7", 32'(cpPopValid), 32'h0, "slot0 has priority");
    @(negedge clk); recvReady = '0;
    #1 chk("R4", 32'(recvValid), 32'h0, "queue drained by slot0");
  endtask

  task automatic t_active();
    activeCnt = 3'd2;
    #1 chk("R5", 32'(sendReady), 32'h3, "two active");
    sendValid = 4'b0010; sendData[1*DW +: DW] = 16'hB2B2;
    @(negedge clk); sendValid = '0;
    #1 chk("R5", 32'(recvValid), 32'h1, "slot1 wraps at count 2");
    chk("R5", 32'(rd(0)), 32'hB2B2, "wrapped data");
    cpPopReady = 1'b1;
    @(negedge clk); cpPopReady = 1'b0;
    activeCnt = 3'd0;
    #1 chk("R5", 32'(sendReady), 32'h1, "zero counts as one");
    sendValid = 4'b0001; sendData[0 +: DW] = 16'hC0C0;
    @(negedge clk); sendValid = '0;
    #1 chk("R5", 32'(rd(0)), 32'hC0C0, "slot0 to itself");
    recvReady = 4'b0001;
    @(negedge clk); recvReady = '0;
    activeCnt = 3'd7;
    #1 chk("R5", 32'(sendReady), 32'hF, "above max counts as max");
    activeCnt = 3'd4;
    sendValid = 4'b0010; sendData[1*DW +: DW] = 16'hD2D2;
    @(negedge clk); sendValid = '0;
    activeCnt = 3'd2;
    #1 chk("R5", 32'(recvValid), 32'h0, "inactive slot2 hidden");
    activeCnt = 3'd4;
    #1 chk("R5", 32'(rd(2)), 32'hD2D2, "hop kept while hidden");
    chk("R5", 32'(recvValid), 32'h4, "slot2 visible again");
    recvReady = 4'b0100;
    @(negedge clk); recvReady = '0;
  endtask

  task automatic t_cp_fifo();
    for (int i = 0; i < 4; i++) begin
      cpPushValid = 1'b1; cpPushData = 16'hF000 + 16'(i);
      #1 chk("R6", 32'(cpPushReady), 32'h1, "push accepted");
      @(negedge clk);
    end
    cpPushValid = 1'b0;
    #1 chk("R8", 32'(cpPushReady), 32'h0, "full blocks push");
    chk("R8", 32'(sendReady[3]), 32'h0, "full blocks last slot");
    cpPushValid = 1'b1; cpPushData = 16'hEEEE;
    @(negedge clk); cpPushValid = 1'b0;
    cpPopReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R8", 32'(cpPopData), 32'hF000 + 32'(i), "arrival order");
      @(negedge clk);
    end
    cpPopReady = 1'b0;
    #1 chk("R8", 32'(cpPopValid), 32'h0, "empty after drain, full push dropped");
    chk("R8", 32'(recvValid[0]), 32'h0, "slot0 sees empty");
  endtask

  task automatic t_priority();
    sendValid = 4'b1000; sendData[3*DW +: DW] = 16'h3333;
    cpPushValid = 1'b1; cpPushData = 16'h4444;
    #1 chk("R6", 32'(cpPushReady), 32'h0, "slot write wins");
    chk("R6", 32'(sendReady[3]), 32'h1, "last slot accepted");
    @(negedge clk); sendValid = '0;
    #1 chk("R6", 32'(cpPushReady), 32'h1, "push retried");
    @(negedge clk); cpPushValid = 1'b0;
    cpPopReady = 1'b1;
    #1 chk("R6", 32'(cpPopData), 32'h3333, "slot value first");
    @(negedge clk);
    #1 chk("R6", 32'(cpPopData), 32'h4444, "push value second");
    @(negedge clk); cpPopReady = 1'b0;
    #1 chk("R8", 32'(cpPopValid), 32'h0, "empty again");
  endtask

  initial begin
    #4000000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_chain();
    t_wrap();
    t_active();
    t_cp_fifo();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule